// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects service requests from five sources and presents at most one of them to the CPU at a time. The sources are two external request lines, two timer-overflow flags and one serial source. The serial source is the OR of a receive-done flag and a transmit-done flag. Each source has its own enable bit, and a global enable gates all of them. A priority register places each source in a high or a low level. Inside a level, a fixed polling order decides which source wins.

The controller tracks nesting with one in-service bit per level. A high-level request may preempt a low-level handler. A request never preempts a handler of its own level, and nothing preempts a high-level handler. While a request is granted, the block raises `cpu_irq` and drives the 16-bit vector address of the winner. The CPU pulses `int_ack` when it takes the vector and pulses `int_ret` when the handler finishes. Requests that cannot be granted stay pending and are presented once the blocking level returns. Software writes the enable, priority and timer-flag registers through a simple write port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every enable bit and both timer flags are 0, so `cpu_irq` stays 0 and `vec_addr` is 0x0000 even when source inputs are active.
- R2: When enable-register bit 7 (global enable) is 0, `cpu_irq` is 0 whatever the per-source enable bits are. An `int_ack` given while `cpu_irq` is 0 changes no state.
- R3: Per-source enable bits sit at enable-register positions bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. A source whose bit is 0 is never granted.
- R4: Vector addresses are 0x0003 external 0, 0x000B timer 0, 0x0013 external 1, 0x001B timer 1, 0x0023 serial, and 0x0000 when no request is granted.
- R5: Inside one level the winner follows the fixed order external 0, timer 0, external 1, timer 1, serial.
- R6: A priority-register bit set to 1 (same bit positions as R3) puts that source in the high level, and any high-level request wins over every low-level request.
- R7: While only a low-level handler is in service, a high-level request is granted and a low-level request is not.
- R8: While a high-level handler is in service, no request is granted. Requests held off in this way remain pending and are granted after the handlers return.
- R9: The serial source requests when `ser_rx_done` or `ser_tx_done` is 1. The controller never clears either flag, so serial requests again after its handler returns if a flag is still set.
- R10: A timer flag is set by a one-cycle `tmr_ovf` pulse or by a software write, and either way it raises a request. A timer flag is cleared in the cycle its request is acknowledged.
- R11: An `int_ret` pulse clears the high-level in-service bit if it is set, and otherwise clears the low-level one.
- R12: Register writes with `wr_en`=1 go by `wr_sel`: 0 writes the enable register (8 bits), 1 writes the priority register (bits 4:0), 2 writes timer flags (bit 0 timer 0, bit 1 timer 1), and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req | input | 2 | External request levels, bit 0 external 0, bit 1 external 1 |
| tmr_ovf | input | 2 | Timer overflow pulses that set the timer flags |
| ser_rx_done | input | 1 | Serial receive-done flag |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 enable, 1 priority, 2 timer flags |
| wr_data | input | 8 | Register write data |
| int_ack | input | 1 | CPU took the vector |
| int_ret | input | 1 | CPU finished a handler |
| cpu_irq | output | 1 | Request to the CPU |
| vec_addr | output | 16 | Vector address of the granted source |
| tmr_flag | output | 2 | Current timer overflow flags |

## Verification
The hardest state to reach is two handlers nested at once: a low-level handler preempted by a high-level one, with a third request held pending behind both. The stimulus acknowledges a software-set timer flag at low level. It then moves the second timer into the high level with a priority write so that the timer preempts, acknowledges it, and raises a serial request. The bench then returns twice and checks that the first return leaves the serial request blocked. Only the second return releases the serial request with its vector.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared constants, source indices and vector computation for the
// two-level interrupt controller. Assumes five sources in polling order.
package irq_pkg;

    localparam int NUM_SRC  = 5;
    localparam int NUM_TMR  = 2;
    localparam int NUM_EXT  = 2;
    localparam int REG_W    = 8;
    localparam int VEC_W    = 16;
    localparam int GLOB_BIT = 7;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;

    // Source index equals polling rank and register bit position
    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        WSEL_ENABLE = 2'd0,
        WSEL_PRIO   = 2'd1,
        WSEL_TFLAG  = 2'd2,
        WSEL_NONE   = 2'd3
    } wsel_e;

    // Vector address of a source index
    function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
        return VEC_W'(VEC_BASE + idx * VEC_STEP);
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
// Module irq_src_bank
// Holds the timer overflow flags and builds the raw request vector in
// polling order. Timer flags are set by hardware pulses or software writes
// and cleared by acknowledge. External and serial inputs are levels held by
// their owners.
module irq_src_bank
    import irq_pkg::*;
#(
    parameter int N_TMR = NUM_TMR,
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TMR-1:0] tmr_hw_set,
    input  logic             tflag_wr,
    input  logic [N_TMR-1:0] tflag_wdata,
    input  logic [N_TMR-1:0] tflag_clr,
    input  logic [1:0]       ext_req,
    input  logic             ser_rx,
    input  logic             ser_tx,
    output logic [N_TMR-1:0] tmr_flag,
    output logic [N_SRC-1:0] raw_req
);

    genvar gi;
    generate
        for (gi = 0; gi < N_TMR; gi++) begin : g_tflag
            // Timer flag: write or clear, then hardware set wins
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tmr_flag[gi] <= 1'b0;
                end else if (tmr_hw_set[gi]) begin
                    tmr_flag[gi] <= 1'b1;
                end else if (tflag_wr) begin
                    tmr_flag[gi] <= tflag_wdata[gi];
                end else if (tflag_clr[gi]) begin
                    tmr_flag[gi] <= 1'b0;
                end
            end

            AST_TFLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
                (tflag_clr[gi] && !tmr_hw_set[gi] && !tflag_wr) |=> !tmr_flag[gi]); // R10
        end
    endgenerate

    // Assemble requests in polling order
    always_comb begin
        raw_req           = '0;
        raw_req[SRC_EXT0] = ext_req[0];
        raw_req[SRC_TMR0] = tmr_flag[0];
        raw_req[SRC_EXT1] = ext_req[1];
        raw_req[SRC_TMR1] = tmr_flag[1];
        raw_req[SRC_SER]  = ser_rx | ser_tx;
    end

endmodule

// File: rtl/irq_arbiter.sv
// Module irq_arbiter
// Masks raw requests, splits them into two levels and picks one winner
// under the nesting rules: nothing while high is in service, only high
// while low is in service. Lowest index wins inside a level.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raw_req,
    input  logic [N_SRC-1:0] en_bits,
    input  logic             glob_en,
    input  logic [N_SRC-1:0] prio_bits,
    input  logic             svc_hi,
    input  logic             svc_lo,
    output logic [N_SRC-1:0] grant,
    output logic             grant_hi,
    output logic             any_grant
);

    logic [N_SRC-1:0] req_hi;
    logic [N_SRC-1:0] req_lo;
    logic [N_SRC-1:0] pick;
    logic             allow_hi;
    logic             allow_lo;

    // Split masked requests by level
    always_comb begin
        req_hi = raw_req & en_bits & {N_SRC{glob_en}} & prio_bits;
        req_lo = raw_req & en_bits & {N_SRC{glob_en}} & ~prio_bits;
    end

    // Apply nesting rules to choose the candidate level
    always_comb begin
        allow_hi = !svc_hi;
        allow_lo = !svc_hi && !svc_lo;
        grant_hi = allow_hi && (|req_hi);
        if (grant_hi) begin
            pick = req_hi;
        end else if (allow_lo) begin
            pick = req_lo;
        end else begin
            pick = '0;
        end
    end

    // Fixed polling order: lowest set index wins
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pick[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any_grant = found;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5
    AST_HI_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hi |-> !any_grant); // R8
    AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_lo && any_grant) |-> (grant & prio_bits) != '0); // R7
    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !any_grant); // R2

endmodule

// File: rtl/irq_nest_track.sv
// Module irq_nest_track
// Keeps one in-service bit per level. Acknowledge sets the level of the
// taken request. Return clears the high level first, else the low level.
// Assumes the CPU returns once for each acknowledge.
module irq_nest_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_take,
    input  logic ack_hi,
    input  logic ret,
    output logic svc_hi,
    output logic svc_lo
);

    // Update in-service bits: return first, then acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_hi <= 1'b0;
            svc_lo <= 1'b0;
        end else begin
            if (ret) begin
                if (svc_hi) begin
                    svc_hi <= 1'b0;
                end else begin
                    svc_lo <= 1'b0;
                end
            end
            if (ack_take) begin
                if (ack_hi) begin
                    svc_hi <= 1'b1;
                end else begin
                    svc_lo <= 1'b1;
                end
            end
        end
    end

    AST_RET_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && svc_hi && !ack_take) |=> (!svc_hi && svc_lo == $past(svc_lo))); // R11
    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && ack_hi) |=> svc_hi); // R7

endmodule

// File: rtl/irq_prio_ctrl.sv
// Module irq_prio_ctrl
// Top of the two-level interrupt controller. Holds the enable and priority
// registers, wires the source bank, arbiter and nesting tracker, and
// produces the CPU request and vector. Assumes int_ack and int_ret are
// single-cycle pulses from the CPU.
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_req,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               ser_rx_done,
    input  logic               ser_tx_done,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               int_ack,
    input  logic               int_ret,
    output logic               cpu_irq,
    output logic [VEC_W-1:0]   vec_addr,
    output logic [NUM_TMR-1:0] tmr_flag
);

    logic [NUM_SRC-1:0] en_q;
    logic               glob_q;
    logic [NUM_SRC-1:0] prio_q;
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] grant;
    logic               grant_hi;
    logic               any_grant;
    logic               svc_hi;
    logic               svc_lo;
    logic               ack_take;
    logic               tflag_wr;
    logic [NUM_TMR-1:0] tflag_clr;
    logic               unused_wbits;

    assign unused_wbits = ^wr_data[GLOB_BIT-1:NUM_SRC];

    // Enable and priority register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            glob_q <= 1'b0;
            prio_q <= '0;
        end else if (wr_en) begin
            case (wsel_e'(wr_sel))
                WSEL_ENABLE: begin
                    en_q   <= wr_data[NUM_SRC-1:0];
                    glob_q <= wr_data[GLOB_BIT];
                end
                WSEL_PRIO:   prio_q <= wr_data[NUM_SRC-1:0];
                default:     ;
            endcase
        end
    end

    // Acknowledge is taken only when a request is granted
    always_comb begin
        ack_take           = int_ack && any_grant;
        tflag_wr           = wr_en && (wsel_e'(wr_sel) == WSEL_TFLAG);
        tflag_clr          = '0;
        tflag_clr[0]       = ack_take && grant[SRC_TMR0];
        tflag_clr[1]       = ack_take && grant[SRC_TMR1];
    end

    irq_src_bank #(
        .N_TMR (NUM_TMR),
        .N_SRC (NUM_SRC)
    ) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_hw_set  (tmr_ovf),
        .tflag_wr    (tflag_wr),
        .tflag_wdata (wr_data[NUM_TMR-1:0]),
        .tflag_clr   (tflag_clr),
        .ext_req     (ext_req),
        .ser_rx      (ser_rx_done),
        .ser_tx      (ser_tx_done),
        .tmr_flag    (tmr_flag),
        .raw_req     (raw_req)
    );

    irq_arbiter #(
        .N_SRC (NUM_SRC)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_req   (raw_req),
        .en_bits   (en_q),
        .glob_en   (glob_q),
        .prio_bits (prio_q),
        .svc_hi    (svc_hi),
        .svc_lo    (svc_lo),
        .grant     (grant),
        .grant_hi  (grant_hi),
        .any_grant (any_grant)
    );

    irq_nest_track u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_take (ack_take),
        .ack_hi   (grant_hi),
        .ret      (int_ret),
        .svc_hi   (svc_hi),
        .svc_lo   (svc_lo)
    );

    // Encode the one-hot grant into a vector address
    always_comb begin
        vec_addr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                vec_addr = vec_of(i);
            end
        end
        cpu_irq = any_grant;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_q) |-> (!cpu_irq && vec_addr == '0)); // R1
    AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !cpu_irq && !int_ret) |=> (svc_hi == $past(svc_hi) && svc_lo == $past(svc_lo))); // R2

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_req = '0;
    logic [1:0]  tmr_ovf = '0;
    logic        ser_rx_done = 1'b0;
    logic        ser_tx_done = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        int_ack = 1'b0;
    logic        int_ret = 1'b0;
    logic        cpu_irq;
    logic [15:0] vec_addr;
    logic [1:0]  tmr_flag;

    typedef struct {
        logic        irq;
        logic [15:0] vec;
        logic [1:0]  tf;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl uut (
        .clk (clk), .rst_n (rst_n), .ext_req (ext_req), .tmr_ovf (tmr_ovf),
        .ser_rx_done (ser_rx_done), .ser_tx_done (ser_tx_done),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .int_ack (int_ack), .int_ret (int_ret),
        .cpu_irq (cpu_irq), .vec_addr (vec_addr), .tmr_flag (tmr_flag)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    endtask

    task automatic pulse_ack();
        int_ack = 1'b1; step(); int_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        int_ret = 1'b1; step(); int_ret = 1'b0;
    endtask

    // Driver side: push an expected output set for this cycle
    task automatic expect_out(input logic irq, input logic [15:0] vec,
                              input logic [1:0] tf, input string tag);
        exp_t e;
        e.irq = irq; e.vec = vec; e.tf = tf; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: pop expected items and compare after outputs settle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (cpu_irq !== e.irq || vec_addr !== e.vec || tmr_flag !== e.tf) begin
                    n_fail++;
                    $display("FAIL %s: got irq=%0b vec=%h tf=%b, expected irq=%0b vec=%h tf=%b",
                             e.tag, cpu_irq, vec_addr, tmr_flag, e.irq, e.vec, e.tf);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected end of sequence");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: nothing enabled after reset
        ext_req = 2'b11;
        expect_out(1'b0, 16'h0000, 2'b00, "R1 reset masks all");
        step();

        // R2: per-source bits on, global off
        wr_reg(2'd0, 8'h1F);
        expect_out(1'b0, 16'h0000, 2'b00, "R2 global off");
        step();

        // R5 R4: both externals at low level, external 0 first
        wr_reg(2'd0, 8'h9F);
        expect_out(1'b1, 16'h0003, 2'b00, "R5 ext0 before ext1");
        step();
        ext_req = 2'b10;
        expect_out(1'b1, 16'h0013, 2'b00, "R4 ext1 vector");
        step();

        // R10 R12: software-set timer flags request
        ext_req = 2'b00;
        wr_reg(2'd2, 8'h03);
        expect_out(1'b1, 16'h000B, 2'b11, "R10 software timer flags");
        step();

        // R10 R7: ack timer 0 (low) clears its flag, timer 1 low blocked
        pulse_ack();
        expect_out(1'b0, 16'h0000, 2'b10, "R7 low blocks low, R10 flag cleared");
        step();

        // R6 R7: move timer 1 to high level, it preempts
        wr_reg(2'd1, 8'h08);
        expect_out(1'b1, 16'h001B, 2'b10, "R7 high preempts low");
        step();

        // R8: high in service, serial pending stays blocked
        pulse_ack();
        ser_rx_done = 1'b1;
        expect_out(1'b0, 16'h0000, 2'b00, "R8 high in service blocks all");
        step();

        // R11: first return clears high only, low still in service
        pulse_ret();
        expect_out(1'b0, 16'h0000, 2'b00, "R11 return clears high first");
        step();

        // R8 R9: second return releases pending serial
        pulse_ret();
        expect_out(1'b1, 16'h0023, 2'b00, "R8 pending serial granted");
        step();
        ser_rx_done = 1'b0;
        ser_tx_done = 1'b1;
        expect_out(1'b1, 16'h0023, 2'b00, "R9 transmit-done requests");
        step();

        // R9: serial flags not cleared by ack, request returns after return
        pulse_ack();
        expect_out(1'b0, 16'h0000, 2'b00, "R9 serial in service");
        step();
        pulse_ret();
        expect_out(1'b1, 16'h0023, 2'b00, "R9 serial flag kept by controller");
        step();
        ser_tx_done = 1'b0;
        expect_out(1'b0, 16'h0000, 2'b00, "R9 no flags no request");
        step();

        // R3: external 0 masked by its enable bit
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'h84);
        ext_req = 2'b11;
        expect_out(1'b1, 16'h0013, 2'b00, "R3 masked source skipped");
        step();

        // R6: high-level serial beats low-level external 0
        wr_reg(2'd0, 8'h9F);
        wr_reg(2'd1, 8'h10);
        ext_req = 2'b01;
        ser_rx_done = 1'b1;
        expect_out(1'b1, 16'h0023, 2'b00, "R6 high beats polling order");
        step();

        // R5: order inside the high level, hardware timer pulse
        ser_rx_done = 1'b0;
        ext_req = 2'b10;
        wr_reg(2'd1, 8'h1F);
        tmr_ovf = 2'b10;
        step();
        tmr_ovf = 2'b00;
        expect_out(1'b1, 16'h0013, 2'b10, "R5 ext1 before tmr1 in high");
        step();

        // R2: global off hides pending; ack while idle is ignored
        wr_reg(2'd0, 8'h1F);
        expect_out(1'b0, 16'h0000, 2'b10, "R2 global off hides pending");
        step();
        pulse_ack();
        wr_reg(2'd0, 8'h9F);
        expect_out(1'b1, 16'h0013, 2'b10, "R2 idle ack had no effect");
        step();

        // R12: select 3 is ignored
        wr_reg(2'd3, 8'h00);
        expect_out(1'b1, 16'h0013, 2'b10, "R12 unused select ignored");
        step();

        // R4: timer 1 vector after external drops
        ext_req = 2'b00;
        expect_out(1'b1, 16'h001B, 2'b10, "R4 tmr1 vector");
        step();
        step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule